// File: doc/BRIEF.md
# Seconds Counter with Fractional Pulse Divider and Alarm

This block keeps wall-clock time as a 32-bit count of seconds. A slow oscillator, seen here as a one-cycle enable `osc_tick` in the single system clock domain, feeds a fractional divider. Each seconds pulse from that divider advances the counter by one. The divide value is a fixed-point number: an integer count of oscillator ticks and an 8-bit fraction. The fraction is absorbed by stretching some periods by one tick, so the average period matches the programmed value.

Software sets the time in two steps. It writes a staging register, then writes a trigger that copies the staged value into the counter. The live count is read from its own read-only register. A 32-bit alarm time and an arm bit drive a level interrupt. The interrupt is high while the alarm is armed and the count has reached the alarm time. Software drops it by disarming the alarm. Registers sit behind a simple APB-style port. A control bit in the divider register makes the divider take its value from an external input instead of the programmed field, for example from a calibration engine.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the counter reads 0, the alarm is disarmed, `alarm_irq` is low, and the divider register (offset 0x04) reads 0x0080_0000. That value is 32768.0, with the source bit clear.
- R2: A write to the staging register (offset 0x10) leaves the counter unchanged. The staged value reads back at 0x10.
- R3: A write to the trigger register (offset 0x14) with bit 0 set loads the staged value into the counter on that clock edge. A trigger write with bit 0 clear has no effect.
- R4: The live count is read at offset 0x18. Writes to that offset have no effect.
- R5: The divider register holds the integer tick count in bits [30:8] and the fraction in bits [7:0]. With fraction 0 and integer N, `sec_pulse` fires on every Nth `osc_tick`, and each pulse adds one to the counter.
- R6: Each pulse adds the fraction to an 8-bit accumulator. The period that follows a carry out of the accumulator is N+1 ticks. Writing the divider register clears the accumulator and restarts the period. With N=4 and fraction 0x80, the periods are 4, 4, 5, 4, 5.
- R7: With bit 31 of the divider register set, the divide value is taken from `alt_div` in the same fixed-point format.
- R8: `alarm_irq` is high exactly while bit 0 of the alarm-enable register (offset 0x0C) is set and the counter is greater than or equal to the alarm time (offset 0x08).
- R9: Writing 0 to the alarm-enable register drops a pending `alarm_irq` from the next cycle on.
- R10: The counter wraps from 0xFFFF_FFFF to 0 on a seconds pulse.
- R11: When a trigger load and a seconds pulse fall on the same edge, the loaded value wins. The pulse is not added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle enable per slow-oscillator period |
| alt_div | input | 31 | Alternate fixed-point divide value |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register port write strobe |
| paddr | input | 8 | Register byte address |
| pwdata | input | 32 | Register write data |
| prdata | output | 32 | Register read data |
| sec_pulse | output | 1 | One-cycle seconds pulse |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
The assertions assume that `osc_tick` is a single-cycle strobe. They also assume that every register access has a setup phase followed by one access phase, so that each write takes effect on exactly one edge. The bench drives `osc_tick` for one cycle with idle cycles between ticks. Its bus tasks always run setup, access and idle in that order. The load-versus-pulse collision is provoked on purpose by raising a tick during the access phase of a trigger write.

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm #(
  parameter logic [30:0] DIV_RESET = 31'h0080_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        osc_tick,
  input  logic [30:0] alt_div,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [7:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        sec_pulse,
  output logic        alarm_irq
);
  localparam logic [7:0] A_DIV   = 8'h04;
  localparam logic [7:0] A_ALARM = 8'h08;
  localparam logic [7:0] A_ARM   = 8'h0C;
  localparam logic [7:0] A_STAGE = 8'h10;
  localparam logic [7:0] A_TRIG  = 8'h14;
  localparam logic [7:0] A_COUNT = 8'h18;

  logic        use_alt;
  logic [30:0] prog_div;
  logic [23:0] tick_cnt;
  logic [7:0]  frac_acc;
  logic        extra_q;
  logic [31:0] sec_cnt, stage_q, alarm_q;
  logic        arm_q;

  wire wr       = psel & penable & pwrite;
  wire wr_div   = wr && paddr == A_DIV;
  wire wr_alarm = wr && paddr == A_ALARM;
  wire wr_arm   = wr && paddr == A_ARM;
  wire wr_stage = wr && paddr == A_STAGE;
  wire wr_trig  = wr && paddr == A_TRIG && pwdata[0];

  wire [30:0] div_sel  = use_alt ? alt_div : prog_div;
  wire [23:0] limit    = {1'b0, div_sel[30:8]} + {23'd0, extra_q};
  wire        hit      = (tick_cnt + 24'd1) >= limit;
  wire [8:0]  frac_sum = {1'b0, frac_acc} + {1'b0, div_sel[7:0]};

  assign sec_pulse = osc_tick & hit;
  assign alarm_irq = arm_q & (sec_cnt >= alarm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_alt  <= 1'b0;
      prog_div <= DIV_RESET;
      tick_cnt <= '0;
      frac_acc <= '0;
      extra_q  <= 1'b0;
    end else if (wr_div) begin
      use_alt  <= pwdata[31];
      prog_div <= pwdata[30:0];
      tick_cnt <= '0;
      frac_acc <= '0;
      extra_q  <= 1'b0;
    end else if (sec_pulse) begin
      tick_cnt <= '0;
      frac_acc <= frac_sum[7:0];
      extra_q  <= frac_sum[8];
    end else if (osc_tick) begin
      tick_cnt <= tick_cnt + 24'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_cnt <= '0;
      stage_q <= '0;
      alarm_q <= '0;
      arm_q   <= 1'b0;
    end else begin
      if (wr_stage) stage_q <= pwdata;
      if (wr_alarm) alarm_q <= pwdata;
      if (wr_arm)   arm_q   <= pwdata[0];
      if (wr_trig)        sec_cnt <= stage_q;
      else if (sec_pulse) sec_cnt <= sec_cnt + 32'd1;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (paddr)
        A_DIV:   prdata = {use_alt, prog_div};
        A_ALARM: prdata = alarm_q;
        A_ARM:   prdata = {31'd0, arm_q};
        A_STAGE: prdata = stage_q;
        A_COUNT: prdata = sec_cnt;
        default: prdata = '0;
      endcase
    end
  end

  assert_trig_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_trig |=> sec_cnt == $past(stage_q));
  assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stage && !sec_pulse && !wr_trig) |=> $stable(sec_cnt));
  assert_pulse_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !wr_trig) |=> sec_cnt == $past(sec_cnt) + 32'd1);
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_tick && !wr_trig) |=> $stable(sec_cnt));
  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !wr_trig && sec_cnt == 32'hFFFF_FFFF) |=> sec_cnt == 32'd0);
  assert_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_arm && !pwdata[0]) |=> !alarm_irq);
  assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !wr_div) |=> tick_cnt == 24'd0);
endmodule

// File: tb/rtc_sec_alarm_test.sv
module rtc_sec_alarm_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, osc_tick = 0;
  logic [30:0] alt_div = '0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        sec_pulse, alarm_irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  rtc_sec_alarm uut (.clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .alt_div(alt_div),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .sec_pulse(sec_pulse), .alarm_irq(alarm_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit tk = 0);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1; osc_tick = tk;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; osc_tick = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    #1 d = prdata;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic tick(output bit p);
    @(negedge clk); osc_tick = 1;
    #1 p = sec_pulse;
    @(negedge clk); osc_tick = 0;
  endtask

  task automatic period(output int n);
    bit p;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      tick(p); n++;
      if (p) break;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h18, v); chk("R1 count", v, 0);
    rd(8'h04, v); chk("R1 divider", v, 32'h0080_0000);
    rd(8'h0C, v); chk("R1 arm", v, 0);
    chk("R1 irq", {31'd0, alarm_irq}, 0);
  endtask

  task automatic t_staged;
    logic [31:0] v;
    wr(8'h10, 32'h1234_5678);
    rd(8'h18, v); chk("R2 count unchanged", v, 0);
    rd(8'h10, v); chk("R2 stage readback", v, 32'h1234_5678);
    wr(8'h14, 32'h0);
    rd(8'h18, v); chk("R3 trigger bit0 clear", v, 0);
    wr(8'h14, 32'h1);
    rd(8'h18, v); chk("R3 trigger load", v, 32'h1234_5678);
    wr(8'h18, 32'hDEAD_BEEF);
    rd(8'h18, v); chk("R4 read-only count", v, 32'h1234_5678);
  endtask

  task automatic t_integer;
    logic [31:0] v; int n;
    wr(8'h10, 32'd50); wr(8'h14, 1);
    wr(8'h04, 32'h0000_0300);
    for (int k = 0; k < 3; k++) begin
      period(n); chk("R5 period N=3", n, 3);
    end
    rd(8'h18, v); chk("R5 count advanced", v, 53);
  endtask

  task automatic t_fraction;
    int n;
    int exp[5] = '{4, 4, 5, 4, 5};
    wr(8'h04, 32'h0000_0480);
    for (int k = 0; k < 5; k++) begin
      period(n); chk("R6 fractional period", n, exp[k]);
    end
  endtask

  task automatic t_alt;
    int n; logic [31:0] v;
    alt_div = 31'h0000_0200;
    wr(8'h04, 32'h8000_0600);
    rd(8'h04, v); chk("R7 divider readback", v, 32'h8000_0600);
    period(n); chk("R7 alt source period", n, 2);
    period(n); chk("R7 alt source period 2", n, 2);
  endtask

  task automatic t_alarm;
    bit p; logic [31:0] v;
    wr(8'h04, 32'h0000_0100);
    wr(8'h10, 32'd100); wr(8'h14, 1);
    wr(8'h08, 32'd102);
    wr(8'h0C, 0);
    tick(p); tick(p); tick(p);
    #1 chk("R8 disarmed irq low", {31'd0, alarm_irq}, 0);
    wr(8'h10, 32'd100); wr(8'h14, 1);
    wr(8'h0C, 1);
    #1 chk("R8 below alarm", {31'd0, alarm_irq}, 0);
    tick(p);
    #1 chk("R8 one below alarm", {31'd0, alarm_irq}, 0);
    tick(p);
    #1 chk("R8 equal alarm", {31'd0, alarm_irq}, 1);
    tick(p);
    #1 chk("R8 above alarm", {31'd0, alarm_irq}, 1);
    wr(8'h0C, 0);
    #1 chk("R9 disarm clears irq", {31'd0, alarm_irq}, 0);
    rd(8'h18, v); chk("R9 count kept", v, 103);
  endtask

  task automatic t_wrap;
    bit p; logic [31:0] v;
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 1);
    tick(p);
    chk("R10 pulse at wrap", {31'd0, p}, 1);
    rd(8'h18, v); chk("R10 wrap to zero", v, 0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(8'h10, 32'd777);
    wr(8'h14, 1, 1);
    rd(8'h18, v); chk("R11 load beats pulse", v, 777);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_staged;
    t_integer;
    t_fraction;
    t_alt;
    t_alarm;
    t_wrap;
    t_collide;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule